// File: doc/BRIEF.md
# Custom Instruction Residency Controller

This controller sits between a host that issues custom instructions and a reconfigurable region made of a single linear stack of identical rows. Each custom instruction is implemented by a hardware module that occupies a contiguous band of rows. The band is given by its first row and its height in rows. Before any custom instruction may run, the controller checks whether its module is already loaded in the region.

When the module is resident, the controller starts execution at once. It raises a one-cycle execute pulse that carries the module's first row. When the module is absent, the controller stalls the host and looks for a large enough run of free rows. If no run fits, it evicts resident modules in least-recently-used order until one does. It then models the configuration of the module, which costs a fixed number of cycles per row, and issues the execute pulse only when every row is loaded. A request for a module taller than the whole region is refused with an error pulse and does not stall.

The required height of each instruction ID comes from a parameter table. The default table has eight IDs with heights 9, 33, 12, 20, 4, 56, 60 and 1 for IDs 0 to 7, in a 56-row region. The per-row configuration cost defaults to 4500 cycles.

Top module: `rcfg_residency_ctrl`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, busy, exec_valid and err_valid are 0, and the region is empty, so the first module loaded starts at row 0.
- R2: A request for a resident module is a hit. exec_valid is raised by the accepting clock edge, exec_row equals the module's first row, and busy stays 0.
- R3: A request for a non-resident module is a miss. busy rises at the accepting edge and stays 1, with req_ready 0, until the edge that raises exec_valid.
- R4: For a miss needing H rows with E evictions, exec_valid is raised exactly H*ROW_CFG_CYCLES + E + 1 clock edges after the accepting edge.
- R5: A loaded module is placed at the lowest start row whose H consecutive rows are all free, and it always lies inside the region.
- R6: When no free run fits, the valid module with the oldest last use is evicted, one per clock cycle, until a run fits. A use is either a hit or a load.
- R7: A request whose table height exceeds NUM_ROWS raises err_valid at the accepting edge for one cycle. There is no stall, no execute pulse and no change to the resident set.
- R8: exec_valid and err_valid are single-cycle pulses that are never high together. exec_id echoes the accepted request's ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host requests a custom instruction |
| req_id | input | ID_W | Requested instruction ID |
| req_ready | output | 1 | Controller can accept a request |
| busy | output | 1 | Host is stalled (placement or configuration in progress) |
| exec_valid | output | 1 | One-cycle execute pulse |
| exec_id | output | ID_W | ID being executed |
| exec_row | output | ROW_W | First row of the executing module |
| err_valid | output | 1 | One-cycle pulse: request refused as too tall |

## Verification
Directed requests cover the following cases. An empty region shows the reset placement at row 0. A full-height module forces every resident module out and shows the per-cycle eviction count in the stall length. The too-tall ID separates the refusal path from a miss, and a one-row module fills the smallest gaps. A repeated ID separates a hit from a miss by whether busy rises and by the one-edge latency. Seeded random ID streams with random gaps create fragmented regions. There, first-fit placement against other start choices shows up in exec_row, and the LRU order against other victim orders shows up in the stall length and later placements.

// File: rtl/rcfg_pkg.sv
// Package: shared state encoding for the residency controller.
// Assumes: nothing beyond standard SystemVerilog.
package rcfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLACE = 2'd1,
        ST_CFG   = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/rcfg_occupancy.sv
// Module: builds the per-row occupancy map of the region from the residency table.
// Assumes: resident bands never overlap and lie inside the region.
module rcfg_occupancy #(
    parameter int NUM_ROWS = 56,
    parameter int NUM_IDS  = 8,
    parameter int ROW_W    = 6,
    parameter int HT_W     = 8
) (
    input  logic [NUM_IDS-1:0]            slot_valid,
    input  logic [NUM_IDS-1:0][ROW_W-1:0] slot_start,
    input  logic [NUM_IDS-1:0][HT_W-1:0]  slot_height,
    output logic [NUM_ROWS-1:0]           row_busy
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        // Mark row r when any valid band covers it.
        always_comb begin
            row_busy[r] = 1'b0;
            for (int i = 0; i < NUM_IDS; i++) begin
                if (slot_valid[i] &&
                    (r >= int'(slot_start[i])) &&
                    (r <  int'(slot_start[i]) + int'(slot_height[i])))
                    row_busy[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rcfg_fit_finder.sv
// Module: first-fit search for the lowest run of free rows of a given height.
// Assumes: need is between 1 and NUM_ROWS.
module rcfg_fit_finder #(
    parameter int NUM_ROWS = 56,
    parameter int ROW_W    = 6,
    parameter int HT_W     = 8
) (
    input  logic [NUM_ROWS-1:0] row_busy,
    input  logic [HT_W-1:0]     need,
    output logic                fit_found,
    output logic [ROW_W-1:0]    fit_start
);
    // Scan upward and stop at the first free run of the needed length.
    always_comb begin
        int run;
        run       = 0;
        fit_found = 1'b0;
        fit_start = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (row_busy[r]) run = 0;
            else             run = run + 1;
            if (!fit_found && (run >= int'(need)) && (need != '0)) begin
                fit_found = 1'b1;
                fit_start = ROW_W'(r - int'(need) + 1);
            end
        end
    end
endmodule

// File: rtl/rcfg_lru_pick.sv
// Module: chooses the valid slot with the oldest last-use stamp.
// Assumes: stamps are unique; ties fall to the lowest slot index.
module rcfg_lru_pick #(
    parameter int NUM_IDS = 8,
    parameter int ID_W    = 3,
    parameter int STAMP_W = 16
) (
    input  logic [NUM_IDS-1:0]              slot_valid,
    input  logic [NUM_IDS-1:0][STAMP_W-1:0] slot_stamp,
    output logic                            victim_any,
    output logic [ID_W-1:0]                 victim_id
);
    // Linear minimum search over the valid slots.
    always_comb begin
        logic [STAMP_W-1:0] best;
        best       = '1;
        victim_any = 1'b0;
        victim_id  = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (slot_valid[i] && (!victim_any || slot_stamp[i] < best)) begin
                victim_any = 1'b1;
                victim_id  = ID_W'(i);
                best       = slot_stamp[i];
            end
        end
    end
endmodule

// File: rtl/rcfg_residency_ctrl.sv
// Module: residency controller for custom instruction modules in a row-stacked region.
// Hits execute at once. Misses stall the host, evict LRU modules until a first-fit
// run exists, then wait ROW_CFG_CYCLES per row before the execute pulse.
// Assumes: every table height is at least 1; each ID owns one table slot.
module rcfg_residency_ctrl #(
    parameter int NUM_ROWS       = 56,
    parameter int NUM_IDS        = 8,
    parameter int HT_W           = 8,
    parameter int ROW_CFG_CYCLES = 4500,
    parameter int STAMP_W        = 16,
    parameter logic [NUM_IDS-1:0][HT_W-1:0] MOD_HEIGHT =
        {8'd1, 8'd60, 8'd56, 8'd4, 8'd20, 8'd12, 8'd33, 8'd9},
    localparam int ID_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
    localparam int ROW_W = $clog2(NUM_ROWS + 1),
    localparam int CNT_W = $clog2(NUM_ROWS * ROW_CFG_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    output logic            req_ready,
    output logic            busy,
    output logic            exec_valid,
    output logic [ID_W-1:0] exec_id,
    output logic [ROW_W-1:0] exec_row,
    output logic            err_valid
);
    import rcfg_pkg::*;

    ctrl_state_t                   state;
    logic [NUM_IDS-1:0]            tbl_valid;
    logic [NUM_IDS-1:0][ROW_W-1:0] tbl_start;
    logic [NUM_IDS-1:0][HT_W-1:0]  tbl_height;
    logic [NUM_IDS-1:0][STAMP_W-1:0] tbl_stamp;
    logic [STAMP_W-1:0]            use_ctr;
    logic [ID_W-1:0]               cur_id;
    logic [CNT_W-1:0]              cfg_cnt;

    logic [NUM_ROWS-1:0] row_busy;
    logic                fit_found;
    logic [ROW_W-1:0]    fit_start;
    logic                victim_any;
    logic [ID_W-1:0]     victim_id;
    logic [HT_W-1:0]     req_h;
    logic [HT_W-1:0]     cur_h;
    logic                accept;
    logic [CNT_W-1:0]    cfg_load;

    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_h     = MOD_HEIGHT[req_id];
    assign cur_h     = MOD_HEIGHT[cur_id];
    assign cfg_load  = CNT_W'(int'(cur_h) * ROW_CFG_CYCLES - 1);

    rcfg_occupancy #(
        .NUM_ROWS(NUM_ROWS), .NUM_IDS(NUM_IDS), .ROW_W(ROW_W), .HT_W(HT_W)
    ) occ_i (
        .slot_valid (tbl_valid),
        .slot_start (tbl_start),
        .slot_height(tbl_height),
        .row_busy   (row_busy)
    );

    rcfg_fit_finder #(
        .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .HT_W(HT_W)
    ) fit_i (
        .row_busy (row_busy),
        .need     (cur_h),
        .fit_found(fit_found),
        .fit_start(fit_start)
    );

    rcfg_lru_pick #(
        .NUM_IDS(NUM_IDS), .ID_W(ID_W), .STAMP_W(STAMP_W)
    ) lru_i (
        .slot_valid(tbl_valid),
        .slot_stamp(tbl_stamp),
        .victim_any(victim_any),
        .victim_id (victim_id)
    );

    // Control sequencing, residency table upkeep and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tbl_valid  <= '0;
            tbl_start  <= '0;
            tbl_height <= '0;
            tbl_stamp  <= '0;
            use_ctr    <= '0;
            cur_id     <= '0;
            cfg_cnt    <= '0;
            exec_valid <= 1'b0;
            exec_id    <= '0;
            exec_row   <= '0;
            err_valid  <= 1'b0;
        end else begin
            exec_valid <= 1'b0;
            err_valid  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        exec_id <= req_id;
                        if (int'(req_h) > NUM_ROWS) begin
                            err_valid <= 1'b1;
                        end else if (tbl_valid[req_id]) begin
                            exec_valid        <= 1'b1;
                            exec_row          <= tbl_start[req_id];
                            tbl_stamp[req_id] <= use_ctr;
                            use_ctr           <= use_ctr + 1'b1;
                        end else begin
                            cur_id <= req_id;
                            state  <= ST_PLACE;
                        end
                    end
                end
                ST_PLACE: begin
                    if (fit_found) begin
                        tbl_valid[cur_id]  <= 1'b1;
                        tbl_start[cur_id]  <= fit_start;
                        tbl_height[cur_id] <= cur_h;
                        tbl_stamp[cur_id]  <= use_ctr;
                        use_ctr            <= use_ctr + 1'b1;
                        cfg_cnt            <= cfg_load;
                        state              <= ST_CFG;
                    end else if (victim_any) begin
                        tbl_valid[victim_id] <= 1'b0;
                    end
                end
                ST_CFG: begin
                    if (cfg_cnt == '0) begin
                        exec_valid <= 1'b1;
                        exec_row   <= tbl_start[cur_id];
                        state      <= ST_IDLE;
                    end else begin
                        cfg_cnt <= cfg_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rcfg_residency_chk.sv
// Module: protocol checker for the residency controller, bound to the top.
// Assumes: MOD_HEIGHT matches the top's parameter.
module rcfg_residency_chk #(
    parameter int NUM_ROWS = 56,
    parameter int NUM_IDS  = 8,
    parameter int HT_W     = 8,
    parameter int ID_W     = 3,
    parameter int ROW_W    = 6,
    parameter logic [NUM_IDS-1:0][HT_W-1:0] MOD_HEIGHT = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             busy,
    input logic             exec_valid,
    input logic [ID_W-1:0]  exec_id,
    input logic [ROW_W-1:0] exec_row,
    input logic             err_valid
);
    // Stall only begins from an accepted request.
    assert_stall_from_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));

    // Leaving the stall always coincides with the execute pulse.
    assert_stall_ends_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> exec_valid);

    // A refusal never comes with a stall.
    assert_reject_nostall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !busy);

    // Executing band lies inside the region.
    assert_band_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (int'(exec_row) + int'(MOD_HEIGHT[exec_id]) <= NUM_ROWS));

    // Execute and refusal pulses are exclusive.
    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_valid && err_valid));
endmodule

bind rcfg_residency_ctrl rcfg_residency_chk #(
    .NUM_ROWS(NUM_ROWS), .NUM_IDS(NUM_IDS), .HT_W(HT_W),
    .ID_W(ID_W), .ROW_W(ROW_W), .MOD_HEIGHT(MOD_HEIGHT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .exec_valid(exec_valid), .exec_id(exec_id),
    .exec_row(exec_row), .err_valid(err_valid)
);

// File: tb/rcfg_residency_ctrl_tb.sv
// Bench: directed corners plus seeded random ID streams, checked against a model.
module rcfg_residency_ctrl_tb_top;
    localparam int NR  = 56;
    localparam int NI  = 8;
    localparam int CYC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_id = '0;
    logic       req_ready, busy, exec_valid, err_valid;
    logic [2:0] exec_id;
    logic [5:0] exec_row;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    int hts [NI] = '{9, 33, 12, 20, 4, 56, 60, 1};
    bit m_valid [NI];
    int m_start [NI];
    int m_stamp [NI];
    int m_ctr;

    always #2 clk = ~clk;

    rcfg_residency_ctrl #(.ROW_CFG_CYCLES(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_ready(req_ready), .busy(busy), .exec_valid(exec_valid),
        .exec_id(exec_id), .exec_row(exec_row), .err_valid(err_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_fit(input int h);
        bit occ [NR];
        int run = 0;
        for (int r = 0; r < NR; r++) occ[r] = 0;
        for (int i = 0; i < NI; i++)
            if (m_valid[i])
                for (int r = m_start[i]; r < m_start[i] + hts[i]; r++) occ[r] = 1;
        for (int r = 0; r < NR; r++) begin
            run = occ[r] ? 0 : run + 1;
            if (run >= h) return r - h + 1;
        end
        return -1;
    endfunction

    function automatic int lru_victim();
        int v = -1;
        for (int i = 0; i < NI; i++)
            if (m_valid[i] && (v < 0 || m_stamp[i] < m_stamp[v])) v = i;
        return v;
    endfunction

    // Issue one request and check its outcome against the model.
    task automatic do_req(input int id, input int gap);
        int h, st, ev, lat, n;
        bit hit;
        repeat (gap) @(negedge clk);
        while (!req_ready) @(negedge clk);
        h = hts[id];
        hit = m_valid[id];
        ev = 0; st = 0;
        if (h <= NR) begin
            if (hit) begin
                st = m_start[id];
            end else begin
                st = first_fit(h);
                while (st < 0) begin
                    m_valid[lru_victim()] = 0;
                    ev++;
                    st = first_fit(h);
                end
                m_valid[id] = 1;
                m_start[id] = st;
            end
            m_stamp[id] = m_ctr;
            m_ctr++;
        end
        req_valid = 1'b1;
        req_id = 3'(id);
        @(negedge clk);
        req_valid = 1'b0;
        if (h > NR) begin
            check("R7 err_valid", int'(err_valid), 1);
            check("R7 busy", int'(busy), 0);
            check("R8 exec_valid on reject", int'(exec_valid), 0);
            @(negedge clk);
            check("R8 err pulse width", int'(err_valid), 0);
            return;
        end
        if (hit) begin
            check("R2 hit exec_valid", int'(exec_valid), 1);
            check("R2 hit exec_row", int'(exec_row), st);
            check("R2 hit busy", int'(busy), 0);
            check("R8 exec_id", int'(exec_id), id);
        end else begin
            check("R3 miss busy", int'(busy), 1);
            check("R3 miss ready", int'(req_ready), 0);
            lat = h * CYC + ev + 2;
            n = 1;
            while (!exec_valid && n < 1000) begin
                @(negedge clk);
                n++;
            end
            check("R4 stall length", n, lat);
            check("R5 R6 placement row", int'(exec_row), st);
            check("R8 exec_id", int'(exec_id), id);
            check("R3 busy released", int'(busy), 0);
        end
        @(negedge clk);
        check("R8 exec pulse width", int'(exec_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        int unused;
        seed = 7;
        unused = $urandom(seed);
        for (int i = 0; i < NI; i++) begin
            m_valid[i] = 0; m_start[i] = 0; m_stamp[i] = 0;
        end
        m_ctr = 0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", int'(req_ready), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 exec_valid", int'(exec_valid), 0);
        check("R1 err_valid", int'(err_valid), 0);
        // Directed corners
        do_req(1, 0);   // R1 first load at row 0
        do_req(1, 0);   // R2 hit
        do_req(0, 1);   // R5 stacked above
        do_req(6, 0);   // R7 too tall
        do_req(3, 2);
        do_req(7, 0);   // 1-row module
        do_req(0, 0);   // hit refreshes LRU
        do_req(5, 0);   // R6 full height evicts all
        do_req(4, 0);
        do_req(2, 1);
        do_req(5, 0);   // R6 evictions again
        // Random stream
        for (int k = 0; k < 200; k++)
            do_req(int'($urandom_range(0, NI - 1)), int'($urandom_range(0, 3)));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule